// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Network

This block sits at the execute stage of a five-stage in-order integer pipeline. It chooses, for the instruction now in execute, the values that feed the two ALU operand ports, the next memory address register value and the next store-data register value. When that instruction reads a register that an older instruction still in flight will write, the block replaces the value latched at decode with a newer one. The newer value can be the ALU result of the instruction one slot ahead, the load data of the instruction in writeback, or a copy of load data held back by one cycle.

The one-cycle-old copy of load data, and the register number and class of the instruction that produced it, are kept inside the block. Two loads in a row can therefore each bypass to a later consumer. All outputs are combinational functions of the current inputs and that small piece of state. Stalling, the ALU itself and the memory are outside the block.

Top module: `fwd_exec_bypass`

## Requirements
- R1: Instruction words use bits [31:29] as class (0 no-op, 1 ALU, 2 load, 3 store, 4 branch, 5 jump, 6 and 7 treated as no-op), bit 28 as the immediate-form flag, [27:23] as destination, [22:18] as first source and [17:13] as second source. When no older slot matches, the ALU operands are `a_lat` and `b_lat` unchanged.
- R2: When the memory-slot instruction is of class ALU and its destination equals a source of the execute instruction, that operand takes `c_res`. This applies to either operand, and to both operands at once.
- R3: When the writeback-slot instruction is a load whose destination equals a source, and R2 does not apply to that operand, the operand takes `lmdr`. This holds whatever the older slot holds.
- R4: When the writeback-slot instruction is a load and does not match, and the instruction that left writeback one cycle earlier was a load whose destination equals the source, the operand takes the `lmdr` value from one cycle earlier. If the writeback slot is not a load, that older load is not used.
- R5: Among matching producers, the youngest wins. The memory slot comes before the writeback slot, and the writeback slot before the slot one past writeback.
- R6: Only ALU instructions in the memory slot, and loads in the later slots, forward. A load in the memory slot, an ALU instruction in the writeback slot, and stores, branches, jumps and no-ops in any slot never change an operand.
- R7: For an immediate-form execute instruction, `alu_b` equals `imm` and only the first operand is forwarded. For a register-form instruction, `alu_b` is the forwarded second operand.
- R8: For a load or store in execute, `mar_next` is the forwarded first operand plus `imm`, modulo 2^XLEN. For any other class it is zero.
- R9: For a store in execute, `smdr_next` is `c_res` when the memory slot is an ALU instruction whose destination equals the second source, and `b_lat` otherwise. For any other class it is zero.
- R10: A synchronous active-high reset clears the held load copy to zero and marks the slot one past writeback as a no-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ex_ir | input | 32 | Instruction word in the execute slot |
| mem_ir | input | 32 | Instruction word in the memory slot |
| wb_ir | input | 32 | Instruction word in the writeback slot |
| a_lat | input | XLEN | First operand latched at decode |
| b_lat | input | XLEN | Second operand latched at decode |
| c_res | input | XLEN | ALU result of the previous execute cycle |
| lmdr | input | XLEN | Load data of the writeback-slot instruction |
| imm | input | XLEN | Sign-extended immediate of the execute instruction |
| alu_a | output | XLEN | First ALU operand |
| alu_b | output | XLEN | Second ALU operand |
| mar_next | output | XLEN | Next memory address register value |
| smdr_next | output | XLEN | Next store-data register value |

## Verification
On every cycle the assertions check these behaviours: the ALU-result bypass, the immediate taking the second port, the fall-back to the latched values when nothing matches, the store data taking `b_lat` when there is no match, the address sum, and the held load copy being delivered one cycle later. The bench scenarios show the rest. Priority among several simultaneous matches needs deliberate stimulus, as do the producers that must not forward and two loads in a row. A reset that lands while a load is in writeback, so that the held copy must be discarded, also needs a scenario of its own.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    localparam int IW    = 32;
    localparam int REG_W = 5;

    typedef enum logic [2:0] {
        CL_NOP    = 3'd0,
        CL_ALU    = 3'd1,
        CL_LOAD   = 3'd2,
        CL_STORE  = 3'd3,
        CL_BRANCH = 3'd4,
        CL_JUMP   = 3'd5
    } iclass_e;

    typedef enum logic [1:0] {
        SRC_LATCH = 2'd0,
        SRC_C     = 2'd1,
        SRC_LMDR  = 2'd2,
        SRC_LMDR1 = 2'd3
    } fsrc_e;

    function automatic iclass_e ir_class(input logic [IW-1:0] w);
        iclass_e c;
        case (w[31:29])
            3'd1:    c = CL_ALU;
            3'd2:    c = CL_LOAD;
            3'd3:    c = CL_STORE;
            3'd4:    c = CL_BRANCH;
            3'd5:    c = CL_JUMP;
            default: c = CL_NOP;
        endcase
        return c;
    endfunction

    function automatic logic ir_imm(input logic [IW-1:0] w);
        return w[28];
    endfunction

    function automatic logic [REG_W-1:0] ir_dest(input logic [IW-1:0] w);
        return w[27:23];
    endfunction

    function automatic logic [REG_W-1:0] ir_src1(input logic [IW-1:0] w);
        return w[22:18];
    endfunction

    function automatic logic [REG_W-1:0] ir_src2(input logic [IW-1:0] w);
        return w[17:13];
    endfunction

    function automatic logic is_mem_class(input iclass_e c);
        return (c == CL_LOAD) || (c == CL_STORE);
    endfunction

endpackage

// File: rtl/fwd_late_stage.sv
module fwd_late_stage
    import fwd_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wb_is_load,
    input  logic [REG_W-1:0] wb_dest,
    input  logic [XLEN-1:0]  lmdr,
    output logic             late_is_load,
    output logic [REG_W-1:0] late_dest,
    output logic [XLEN-1:0]  lmdr1
);

    always_ff @(posedge clk) begin
        if (rst) begin
            late_is_load <= 1'b0;
            late_dest    <= '0;
            lmdr1        <= '0;
        end else begin
            late_is_load <= wb_is_load;
            late_dest    <= wb_dest;
            lmdr1        <= lmdr;
        end
    end

endmodule

// File: rtl/fwd_operand.sv
module fwd_operand
    import fwd_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [REG_W-1:0] src,
    input  logic             mem_is_alu,
    input  logic [REG_W-1:0] mem_dest,
    input  logic             wb_is_load,
    input  logic [REG_W-1:0] wb_dest,
    input  logic             late_is_load,
    input  logic [REG_W-1:0] late_dest,
    input  logic [XLEN-1:0]  latched,
    input  logic [XLEN-1:0]  c_res,
    input  logic [XLEN-1:0]  lmdr,
    input  logic [XLEN-1:0]  lmdr1,
    output fsrc_e            sel,
    output logic [XLEN-1:0]  value
);

    logic hit_mem, hit_wb, hit_late;

    always_comb begin
        hit_mem  = mem_is_alu && (mem_dest == src);
        hit_wb   = wb_is_load && (wb_dest == src);
        hit_late = wb_is_load && late_is_load && (late_dest == src);

        if (hit_mem)       sel = SRC_C;
        else if (hit_wb)   sel = SRC_LMDR;
        else if (hit_late) sel = SRC_LMDR1;
        else               sel = SRC_LATCH;

        case (sel)
            SRC_C:     value = c_res;
            SRC_LMDR:  value = lmdr;
            SRC_LMDR1: value = lmdr1;
            default:   value = latched;
        endcase
    end

endmodule

// File: rtl/fwd_addr_data.sv
module fwd_addr_data
    import fwd_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  iclass_e          ex_cls,
    input  logic [REG_W-1:0] ex_src2,
    input  logic [XLEN-1:0]  first_op,
    input  logic [XLEN-1:0]  imm,
    input  logic             mem_is_alu,
    input  logic [REG_W-1:0] mem_dest,
    input  logic [XLEN-1:0]  b_lat,
    input  logic [XLEN-1:0]  c_res,
    output logic [XLEN-1:0]  mar_next,
    output logic [XLEN-1:0]  smdr_next
);

    logic data_hit;

    always_comb begin
        data_hit  = mem_is_alu && (mem_dest == ex_src2);
        mar_next  = '0;
        smdr_next = '0;
        if (is_mem_class(ex_cls)) begin
            mar_next = first_op + imm;
        end
        if (ex_cls == CL_STORE) begin
            smdr_next = data_hit ? c_res : b_lat;
        end
    end

endmodule

// File: rtl/fwd_exec_bypass.sv
module fwd_exec_bypass
    import fwd_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [IW-1:0]   ex_ir,
    input  logic [IW-1:0]   mem_ir,
    input  logic [IW-1:0]   wb_ir,
    input  logic [XLEN-1:0] a_lat,
    input  logic [XLEN-1:0] b_lat,
    input  logic [XLEN-1:0] c_res,
    input  logic [XLEN-1:0] lmdr,
    input  logic [XLEN-1:0] imm,
    output logic [XLEN-1:0] alu_a,
    output logic [XLEN-1:0] alu_b,
    output logic [XLEN-1:0] mar_next,
    output logic [XLEN-1:0] smdr_next
);

    localparam int NOPS = 2;

    iclass_e          ex_cls;
    logic             ex_imm;
    logic [REG_W-1:0] src [NOPS];
    logic [XLEN-1:0]  lat [NOPS];
    logic [XLEN-1:0]  fwd [NOPS];
    fsrc_e            sel [NOPS];

    logic             mem_is_alu, wb_is_load, late_is_load;
    logic [REG_W-1:0] mem_dest, wb_dest, late_dest;
    logic [XLEN-1:0]  lmdr1;

    always_comb begin
        ex_cls     = ir_class(ex_ir);
        ex_imm     = ir_imm(ex_ir);
        src[0]     = ir_src1(ex_ir);
        src[1]     = ir_src2(ex_ir);
        lat[0]     = a_lat;
        lat[1]     = b_lat;
        mem_is_alu = (ir_class(mem_ir) == CL_ALU);
        mem_dest   = ir_dest(mem_ir);
        wb_is_load = (ir_class(wb_ir) == CL_LOAD);
        wb_dest    = ir_dest(wb_ir);
    end

    fwd_late_stage #(.XLEN(XLEN)) u_late (
        .clk          (clk),
        .rst          (rst),
        .wb_is_load   (wb_is_load),
        .wb_dest      (wb_dest),
        .lmdr         (lmdr),
        .late_is_load (late_is_load),
        .late_dest    (late_dest),
        .lmdr1        (lmdr1)
    );

    for (genvar g = 0; g < NOPS; g++) begin : g_op
        fwd_operand #(.XLEN(XLEN)) u_op (
            .src          (src[g]),
            .mem_is_alu   (mem_is_alu),
            .mem_dest     (mem_dest),
            .wb_is_load   (wb_is_load),
            .wb_dest      (wb_dest),
            .late_is_load (late_is_load),
            .late_dest    (late_dest),
            .latched      (lat[g]),
            .c_res        (c_res),
            .lmdr         (lmdr),
            .lmdr1        (lmdr1),
            .sel          (sel[g]),
            .value        (fwd[g])
        );
    end

    always_comb begin
        alu_a = fwd[0];
        alu_b = ex_imm ? imm : fwd[1];
    end

    fwd_addr_data #(.XLEN(XLEN)) u_ad (
        .ex_cls     (ex_cls),
        .ex_src2    (src[1]),
        .first_op   (fwd[0]),
        .imm        (imm),
        .mem_is_alu (mem_is_alu),
        .mem_dest   (mem_dest),
        .b_lat      (b_lat),
        .c_res      (c_res),
        .mar_next   (mar_next),
        .smdr_next  (smdr_next)
    );

endmodule

// File: rtl/fwd_exec_bypass_chk.sv
module fwd_exec_bypass_chk
    import fwd_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic [IW-1:0]   ex_ir,
    input logic [IW-1:0]   mem_ir,
    input logic [IW-1:0]   wb_ir,
    input logic [XLEN-1:0] a_lat,
    input logic [XLEN-1:0] b_lat,
    input logic [XLEN-1:0] c_res,
    input logic [XLEN-1:0] lmdr,
    input logic [XLEN-1:0] imm,
    input logic [XLEN-1:0] alu_a,
    input logic [XLEN-1:0] alu_b,
    input logic [XLEN-1:0] mar_next,
    input logic [XLEN-1:0] smdr_next
);

    logic m_alu, w_load, any1, m_hit2;
    logic [REG_W-1:0] s1, s2;

    always_comb begin
        s1     = ir_src1(ex_ir);
        s2     = ir_src2(ex_ir);
        m_alu  = (ir_class(mem_ir) == CL_ALU);
        w_load = (ir_class(wb_ir) == CL_LOAD);
        m_hit2 = m_alu && (ir_dest(mem_ir) == s2);
        any1   = (m_alu && ir_dest(mem_ir) == s1) || (w_load && ir_dest(wb_ir) == s1) || w_load;
    end

    AST_C_BYPASS_A: assert property (@(posedge clk) disable iff (rst)
        (m_alu && ir_dest(mem_ir) == s1) |-> (alu_a == c_res)); // R2

    AST_IMM_SECOND: assert property (@(posedge clk) disable iff (rst)
        ir_imm(ex_ir) |-> (alu_b == imm)); // R7

    AST_NO_MATCH_LATCH: assert property (@(posedge clk) disable iff (rst)
        !any1 |-> (alu_a == a_lat)); // R1

    AST_STORE_DATA_B: assert property (@(posedge clk) disable iff (rst)
        (ir_class(ex_ir) == CL_STORE && !m_hit2) |-> (smdr_next == b_lat)); // R9

    AST_ADDR_SUM: assert property (@(posedge clk) disable iff (rst)
        is_mem_class(ir_class(ex_ir)) |-> (mar_next == alu_a + imm)); // R8

    AST_LATE_COPY: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && w_load && $past(ir_class(wb_ir) == CL_LOAD)
         && s1 == $past(ir_dest(wb_ir)) && s1 != ir_dest(wb_ir)
         && !(m_alu && ir_dest(mem_ir) == s1))
        |-> (alu_a == $past(lmdr))); // R4

endmodule

bind fwd_exec_bypass fwd_exec_bypass_chk #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ex_ir     (ex_ir),
    .mem_ir    (mem_ir),
    .wb_ir     (wb_ir),
    .a_lat     (a_lat),
    .b_lat     (b_lat),
    .c_res     (c_res),
    .lmdr      (lmdr),
    .imm       (imm),
    .alu_a     (alu_a),
    .alu_b     (alu_b),
    .mar_next  (mar_next),
    .smdr_next (smdr_next)
);

// File: tb/tb_fwd_exec_bypass.sv
module tb_fwd_exec_bypass;

    localparam int XLEN = 32;
    localparam logic [31:0] AV = 32'h1111_1111;
    localparam logic [31:0] BV = 32'h2222_2222;
    localparam logic [31:0] CV = 32'h3333_3333;
    localparam logic [31:0] LV = 32'h4444_4444;

    function automatic logic [31:0] mk(input int cls, input int im, input int d,
                                       input int s1, input int s2);
        return {cls[2:0], im[0], d[4:0], s1[4:0], s2[4:0], 13'd0};
    endfunction

    typedef struct packed {
        logic [31:0] ex;
        logic [31:0] mem;
        logic [31:0] wb;
        logic [31:0] im;
        logic [31:0] ea;
        logic [31:0] eb;
        logic [31:0] emar;
        logic [31:0] esmdr;
        logic [31:0] req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{mk(1,0,1,2,3),  mk(0,0,0,0,0),  mk(0,0,0,0,0), 32'd8,  AV, BV, 32'd0, 32'd0, 32'd1},  // R1
        '{mk(1,0,1,2,3),  mk(1,0,2,0,0),  mk(0,0,0,0,0), 32'd8,  CV, BV, 32'd0, 32'd0, 32'd2},  // R2
        '{mk(1,0,1,2,3),  mk(1,0,3,0,0),  mk(0,0,0,0,0), 32'd8,  AV, CV, 32'd0, 32'd0, 32'd2},  // R2
        '{mk(1,0,1,4,4),  mk(1,0,4,0,0),  mk(0,0,0,0,0), 32'd8,  CV, CV, 32'd0, 32'd0, 32'd2},  // R2
        '{mk(1,1,1,5,6),  mk(1,0,6,0,0),  mk(0,0,0,0,0), 32'd16, AV, 32'd16, 32'd0, 32'd0, 32'd7}, // R7
        '{mk(1,1,1,5,6),  mk(1,0,5,0,0),  mk(0,0,0,0,0), 32'd16, CV, 32'd16, 32'd0, 32'd0, 32'd7}, // R7
        '{mk(1,0,1,7,9),  mk(0,0,0,0,0),  mk(2,1,7,0,0), 32'd8,  LV, BV, 32'd0, 32'd0, 32'd3},  // R3
        '{mk(1,0,1,7,9),  mk(1,0,7,0,0),  mk(2,1,7,0,0), 32'd8,  CV, BV, 32'd0, 32'd0, 32'd5},  // R5
        '{mk(1,0,1,7,8),  mk(0,0,0,0,0),  mk(1,0,7,0,0), 32'd8,  AV, BV, 32'd0, 32'd0, 32'd6},  // R6
        '{mk(2,1,1,10,0), mk(1,0,10,0,0), mk(0,0,0,0,0), 32'h20, CV, 32'h20, 32'h3333_3353, 32'd0, 32'd8}, // R8
        '{mk(3,1,0,11,12),mk(1,0,12,0,0), mk(0,0,0,0,0), 32'd4,  AV, 32'd4, 32'h1111_1115, CV, 32'd9},    // R9
        '{mk(3,1,0,11,12),mk(0,0,0,0,0),  mk(2,1,12,0,0),32'd4,  AV, 32'd4, 32'h1111_1115, BV, 32'd9},    // R9
        '{mk(3,1,0,11,12),mk(0,0,0,0,0),  mk(2,1,11,0,0),32'd4,  LV, 32'd4, 32'h4444_4448, BV, 32'd8},    // R8
        '{mk(1,0,1,13,14),mk(2,1,13,0,0), mk(0,0,0,0,0), 32'd8,  AV, BV, 32'd0, 32'd0, 32'd6},  // R6
        '{mk(4,0,0,2,0),  mk(1,0,2,0,0),  mk(3,1,0,0,0), 32'd8,  CV, BV, 32'd0, 32'd0, 32'd6}   // R6
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [31:0] ex_ir = '0, mem_ir = '0, wb_ir = '0;
    logic [XLEN-1:0] a_lat = AV, b_lat = BV, c_res = CV, lmdr = LV, imm = '0;
    logic [XLEN-1:0] alu_a, alu_b, mar_next, smdr_next;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fwd_exec_bypass #(.XLEN(XLEN)) dut (
        .clk(clk), .rst(rst), .ex_ir(ex_ir), .mem_ir(mem_ir), .wb_ir(wb_ir),
        .a_lat(a_lat), .b_lat(b_lat), .c_res(c_res), .lmdr(lmdr), .imm(imm),
        .alu_a(alu_a), .alu_b(alu_b), .mar_next(mar_next), .smdr_next(smdr_next)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic flush();
        @(negedge clk);
        ex_ir = '0; mem_ir = '0; wb_ir = '0; lmdr = LV;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R10: reset lands while a load sits in writeback; held copy must be discarded
        repeat (2) @(negedge clk);
        wb_ir = mk(2, 1, 21, 0, 0);
        lmdr  = 32'hDEAD_0001;
        @(negedge clk);
        rst   = 1'b0;
        wb_ir = mk(2, 1, 22, 0, 0);
        lmdr  = 32'hDEAD_0002;
        ex_ir = mk(1, 0, 1, 21, 3);
        #1;
        chk("R10", "alu_a after reset", alu_a, AV);
        chk("R10", "alu_b after reset", alu_b, BV);

        // table walk
        for (int i = 0; i < NV; i++) begin
            flush();
            @(negedge clk);
            ex_ir  = VEC[i].ex;
            mem_ir = VEC[i].mem;
            wb_ir  = VEC[i].wb;
            imm    = VEC[i].im;
            #1;
            chk($sformatf("R%0d", VEC[i].req), "alu_a",     alu_a,     VEC[i].ea);
            chk($sformatf("R%0d", VEC[i].req), "alu_b",     alu_b,     VEC[i].eb);
            chk($sformatf("R%0d", VEC[i].req), "mar_next",  mar_next,  VEC[i].emar);
            chk($sformatf("R%0d", VEC[i].req), "smdr_next", smdr_next, VEC[i].esmdr);
        end

        // R4: back-to-back loads, older one reaches operand one through held copy
        flush();
        @(negedge clk);
        wb_ir = mk(2, 1, 21, 0, 0);
        lmdr  = 32'hAAAA_0001;
        @(negedge clk);
        wb_ir = mk(2, 1, 22, 0, 0);
        lmdr  = 32'hAAAA_0002;
        ex_ir = mk(1, 0, 1, 21, 22);
        imm   = 32'd0;
        #1;
        chk("R4", "alu_a held copy", alu_a, 32'hAAAA_0001);
        chk("R3", "alu_b current load", alu_b, 32'hAAAA_0002);

        // R5: both loads target the same register, the younger wins
        flush();
        @(negedge clk);
        wb_ir = mk(2, 1, 23, 0, 0);
        lmdr  = 32'hBBBB_0001;
        @(negedge clk);
        wb_ir = mk(2, 1, 23, 0, 0);
        lmdr  = 32'hBBBB_0002;
        ex_ir = mk(1, 0, 1, 23, 9);
        #1;
        chk("R5", "alu_a younger load", alu_a, 32'hBBBB_0002);

        // R5: ALU one slot ahead beats both loads
        mem_ir = mk(1, 0, 23, 0, 0);
        #1;
        chk("R5", "alu_a mem over loads", alu_a, CV);

        // R4: older load but writeback slot holds an ALU op, no held-copy bypass
        flush();
        @(negedge clk);
        wb_ir = mk(2, 1, 24, 0, 0);
        lmdr  = 32'hCCCC_0001;
        @(negedge clk);
        wb_ir = mk(1, 0, 9, 0, 0);
        lmdr  = 32'hCCCC_0002;
        ex_ir = mk(1, 0, 1, 24, 9);
        #1;
        chk("R4", "alu_a no held copy when wb not load", alu_a, AV);
        chk("R6", "alu_b ALU in wb not forwarded", alu_b, BV);

        // R8: jump class gives zero address; R9: non-store gives zero data
        flush();
        @(negedge clk);
        ex_ir = mk(5, 1, 0, 2, 3);
        imm   = 32'h40;
        #1;
        chk("R8", "mar_next jump", mar_next, 32'd0);
        chk("R9", "smdr_next jump", smdr_next, 32'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule